// File: doc/BRIEF.md
# DMA Bridge Interrupt Status Register

This block is the single 32-bit control and status register of a DMA bridge. It captures ten single-cycle hardware event pulses: a USB transfer-complete event, a USB address-error event, and, for each of two audio channels, whole-buffer and half-buffer completion events in both the playback and the capture direction. Each captured event sits in a status bit. A companion enable bit, eight positions higher in the word, decides whether that pending event reaches an interrupt output.

The enabled, pending events are folded onto three registered level interrupts. One line carries the USB address error. One carries USB transfer completion and every audio whole-buffer event. One carries every audio half-buffer event. Software reads the whole word and writes it back. A zero written to a status bit acknowledges that bit. A one written to a status bit leaves it alone. Enable bits take the written value directly.

Top module: `dbrg_irq_reg`

## Requirements
- R1: After synchronous reset the register reads all zeros and all three interrupt outputs are low.
- R2: A pulse on evt_i[k] sets a status bit in the cycle after the pulse. The status bit is read position k for k = 0 (USB transfer done) and k = 1 (USB address error). For k = 2..9 it is position k+14: bit 16 channel 0 playback whole, 17 channel 0 playback half, 18 channel 0 capture whole, 19 channel 0 capture half, and bits 20-23 the same four events for channel 1. This happens even when the matching enable is clear.
- R3: A write (wr_en_i high) with 0 in a set status bit clears that bit. A write with 1 in a status bit leaves it unchanged. A status bit is never set by a write.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: Enable bits 31-24 and 9-8 take the written value on every write and hold it otherwise. The enable at position p+8 gates the status at position p.
- R6: Bits 15-10 and 7-2 always read zero and ignore writes.
- R7: irq_err_o is high in a cycle exactly when, in the previous cycle, status bit 1 and enable bit 9 were both set.
- R8: irq_end_o is high exactly when, in the previous cycle, at least one of status bits 0, 16, 18, 20, 22 was set together with its enable.
- R9: irq_half_o is high exactly when, in the previous cycle, at least one of status bits 17, 19, 21, 23 was set together with its enable.
- R10: An interrupt output stays high until every contributing status bit is cleared or masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| evt_i | input | 10 | Event pulses: 0 USB done, 1 USB address error, 2-9 audio events |
| rd_data_o | output | 32 | Current register contents |
| irq_err_o | output | 1 | USB address error interrupt |
| irq_end_o | output | 1 | Transfer-end interrupt |
| irq_half_o | output | 1 | Half-transfer interrupt |

## Verification
Directed patterns fire each event alone with its enable clear and then set. This separates bit placement and line routing per event, and it shows latching while masked. Acknowledge writes are tried three ways: with zeros, with ones, and colliding with a fresh pulse on the same bit. These tell clear, keep and event priority apart. Writes with reserved bits set confirm those bits stay zero. A long pseudo-random run of mixed pulses and writes then compares the word and all three lines against the reference every cycle. This catches any swapped enable offset or wrong grouping of bits onto lines.

// File: rtl/dbrg_pkg.sv
package dbrg_pkg;
  localparam int REG_W   = 32;
  localparam int NUM_EVT = 10;
  localparam int EN_OFS  = 8;
  localparam int NUM_USB = 2;
  localparam int AUD_BASE = 16;
  localparam int NUM_IRQ = 3;

  // status bit position of event k
  function automatic int evt_pos(input int k);
    return (k < NUM_USB) ? k : (k - NUM_USB + AUD_BASE);
  endfunction

  // interrupt line of event k: 0 error, 1 transfer end, 2 half transfer
  function automatic int evt_line(input int k);
    if (k == 1) return 0;
    if (k == 0) return 1;
    return (((k - NUM_USB) % 2) == 0) ? 1 : 2;
  endfunction

  function automatic logic [NUM_EVT-1:0] line_mask(input int ln);
    logic [NUM_EVT-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_EVT; k++) m[k] = (evt_line(k) == ln);
    return m;
  endfunction

  function automatic logic [REG_W-1:0] live_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_EVT; k++) begin
      m[evt_pos(k)] = 1'b1;
      m[evt_pos(k) + EN_OFS] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/dbrg_evt_cell.sv
module dbrg_evt_cell (
  input  logic clk,
  input  logic rst,
  input  logic wr_en_i,
  input  logic wr_st_i,
  input  logic wr_ena_i,
  input  logic evt_i,
  output logic st_o,
  output logic ena_o
);
  logic st_q, ena_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= 1'b0;
      ena_q <= 1'b0;
    end else begin
      st_q <= ((wr_en_i ? wr_st_i : 1'b1) & st_q) | evt_i;
      if (wr_en_i) ena_q <= wr_ena_i;
    end
  end

  assign st_o  = st_q;
  assign ena_o = ena_q;

  assert_evt_wins_R4: assert property (@(posedge clk) disable iff (rst)
    evt_i |=> st_o);
  assert_wr0_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !wr_st_i && !evt_i) |=> !st_o);
  assert_wr1_keeps_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_st_i && st_o) |=> st_o);
  assert_no_wr_set_R3: assert property (@(posedge clk) disable iff (rst)
    (!st_o && !evt_i) |=> !st_o);
  assert_ena_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(ena_o));
endmodule

// File: rtl/dbrg_irq_merge.sv
module dbrg_irq_merge
  import dbrg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] pend_i,
  output logic [NUM_IRQ-1:0] irq_o
);
  logic [NUM_IRQ-1:0] irq_q;

  for (genvar ln = 0; ln < NUM_IRQ; ln++) begin : g_line
    localparam logic [NUM_EVT-1:0] MASK = line_mask(ln);
    always_ff @(posedge clk) begin
      if (rst) irq_q[ln] <= 1'b0;
      else     irq_q[ln] <= |(pend_i & MASK);
    end
  end

  assign irq_o = irq_q;

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_o[0] && pend_i[1]) |=> irq_o[0]);
endmodule

// File: rtl/dbrg_irq_reg.sv
module dbrg_irq_reg
  import dbrg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [REG_W-1:0]   rd_data_o,
  output logic               irq_err_o,
  output logic               irq_end_o,
  output logic               irq_half_o
);
  localparam logic [REG_W-1:0] LIVE = live_mask();

  logic [NUM_EVT-1:0] st_v, ena_v;
  logic [NUM_IRQ-1:0] irq_v;

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
    localparam int P = evt_pos(k);
    dbrg_evt_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .wr_en_i  (wr_en_i),
      .wr_st_i  (wr_data_i[P]),
      .wr_ena_i (wr_data_i[P + EN_OFS]),
      .evt_i    (evt_i[k]),
      .st_o     (st_v[k]),
      .ena_o    (ena_v[k])
    );
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NUM_EVT; k++) begin
      rd_data_o[evt_pos(k)]          = st_v[k];
      rd_data_o[evt_pos(k) + EN_OFS] = ena_v[k];
    end
  end

  dbrg_irq_merge u_merge (
    .clk    (clk),
    .rst    (rst),
    .pend_i (st_v & ena_v),
    .irq_o  (irq_v)
  );

  assign irq_err_o  = irq_v[0];
  assign irq_end_o  = irq_v[1];
  assign irq_half_o = irq_v[2];

  assert_reserved_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && |(wr_data_i & ~LIVE)) |=> ((rd_data_o & ~LIVE) == '0));
  assert_err_line_R7: assert property (@(posedge clk) disable iff (rst)
    irq_err_o == $past(rd_data_o[1] & rd_data_o[9]));
  assert_half_line_R9: assert property (@(posedge clk) disable iff (rst)
    irq_half_o == $past(|(rd_data_o[23:16] & rd_data_o[31:24] & 8'hAA)));
  assert_end_line_R8: assert property (@(posedge clk) disable iff (rst)
    irq_end_o == $past((rd_data_o[0] & rd_data_o[8]) |
                       (|(rd_data_o[23:16] & rd_data_o[31:24] & 8'h55))));
endmodule

// File: tb/sim_dbrg_irq_reg.sv
module sim_dbrg_irq_reg;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [9:0]  evt;
  logic [31:0] rd_data;
  logic        irq_err, irq_end, irq_half;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] m_reg;
  logic        m_err, m_end, m_half;

  always #4 clk = ~clk;  // 125 MHz

  dbrg_irq_reg u0 (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .evt_i(evt), .rd_data_o(rd_data),
    .irq_err_o(irq_err), .irq_end_o(irq_end), .irq_half_o(irq_half)
  );

  function automatic int bitof(input int k);
    if (k < 2) return k;
    return k + 14;
  endfunction

  // reference update at a clock edge
  task automatic model_edge(input logic w, input logic [31:0] d, input logic [9:0] e);
    logic [31:0] nx;
    m_err  = m_reg[1] & m_reg[9];
    m_end  = 1'b0;
    m_half = 1'b0;
    if (m_reg[0] & m_reg[8]) m_end = 1'b1;
    for (int b = 16; b < 24; b++)
      if (m_reg[b] & m_reg[b+8]) begin
        if ((b % 2) == 0) m_end = 1'b1; else m_half = 1'b1;
      end
    nx = 32'd0;
    for (int k = 0; k < 10; k++) begin
      int p;
      p = bitof(k);
      nx[p]   = (m_reg[p] & (w ? d[p] : 1'b1)) | e[k];
      nx[p+8] = w ? d[p+8] : m_reg[p+8];
    end
    m_reg = nx;
  endtask

  task automatic cmp(input string tag);
    checks++;
    if (rd_data !== m_reg) begin
      errors++;
      $display("FAIL %s rd_data actual %h expected %h", tag, rd_data, m_reg);
    end
    checks++;
    if ({irq_err, irq_end, irq_half} !== {m_err, m_end, m_half}) begin
      errors++;
      $display("FAIL %s irq err/end/half actual %b%b%b expected %b%b%b",
               tag, irq_err, irq_end, irq_half, m_err, m_end, m_half);
    end
  endtask

  // called at a negedge; returns at the next negedge after comparing
  task automatic step(input logic w, input logic [31:0] d, input logic [9:0] e,
                      input string tag);
    wr_en = w; wr_data = d; evt = e;
    @(posedge clk);
    model_edge(w, d, e);
    @(negedge clk);
    wr_en = 1'b0; wr_data = 32'd0; evt = 10'd0;
    cmp(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 32'd0, 10'd0, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] lf;
    rst = 1'b1; wr_en = 1'b0; wr_data = 32'd0; evt = 10'd0;
    m_reg = 32'd0; m_err = 1'b0; m_end = 1'b0; m_half = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cmp("R1 reset state");

    // R2: each event alone, enables clear -> latches, no interrupt
    for (int k = 0; k < 10; k++) begin
      step(1'b0, 32'd0, 10'(1 << k), "R2 event latch while masked");
      idle("R2 no irq while masked");
      step(1'b1, 32'd0, 10'd0, "R3 clear by zero write");
    end

    // R5/R7/R8/R9: each event alone, its enable set
    for (int k = 0; k < 10; k++) begin
      logic [31:0] en;
      en = 32'd1 << (bitof(k) + 8);
      step(1'b1, en, 10'd0, "R5 enable write");
      step(1'b0, 32'd0, 10'(1 << k), "R2 event latch enabled");
      idle("R7 R8 R9 line routing");
      idle("R10 level held");
      step(1'b1, en | (32'd1 << bitof(k)), 10'd0, "R3 write one keeps");
      idle("R10 still held");
      step(1'b1, 32'd1 << bitof(k), 10'd0, "R10 masked by enable clear");
      idle("R10 line drops after mask");
      step(1'b1, 32'd0, 10'd0, "R3 clear");
    end

    // R4: event and clearing write collide
    step(1'b1, 32'hFF00_0300, 10'h3FF, "R4 collide write enables");
    step(1'b1, 32'hFF00_0300, 10'h3FF, "R4 event beats clear");
    step(1'b1, 32'hFF00_0300, 10'd0, "R3 clear all status");
    idle("R10 lines fall");

    // R6: reserved bits ignore writes
    step(1'b1, 32'hFFFF_FFFF, 10'd0, "R6 reserved read zero");
    step(1'b1, 32'h0000_FCFC, 10'd0, "R6 reserved only write");
    step(1'b1, 32'd0, 10'd0, "R6 clear");

    // mixed pseudo-random traffic
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 3000; i++) begin
      logic w;
      logic [31:0] d;
      logic [9:0] e;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      w = (lf[3:0] == 4'd0);
      d = {lf[31:24] | lf[15:8], 8'hFF & ~lf[23:16], lf[15:0]};
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      e = lf[9:0] & lf[19:10] & lf[29:20];
      step(w, d, e, "R2 R3 R4 R5 R7 R8 R9 mixed traffic");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) cycles++;
endmodule